// File: doc/BRIEF.md
# DS3 Receive Alarm and Interrupt Monitor

This block watches the overhead of a received DS3 signal one M-frame at a time. A single-cycle strobe from the framer carries the two X-bits, the three far-end block error (FEBE) bits, a flag that the frame matched the idle pattern, and flags for P-bit and C-bit parity errors. From these the block keeps the far-end receive failure (yellow alarm) state, tracks the idle-signal condition with a saturating up/down counter, and keeps the most recent FEBE field. It also flags each FEBE value other than all-ones as a far-end block error.

Four line conditions detected elsewhere arrive as levels: alarm indication signal, loss of signal, out of frame, and the application identification bit. The block samples them, shows them in its status registers and notes when they change. Every status change, and every frame that carries a parity error, sets a latched interrupt bit. Each latched bit stays set until software reads the interrupt status register. An interrupt line goes high while any latched bit has its enable set. Software reaches all registers through a byte-wide read/write port. Read data is combinational, and the clear on read takes effect at the clock edge that ends the read cycle.

Top module: `ds3_rx_alarm_mon`

## Requirements
- R1: On a frame strobe, X-bits `00` set the far-end failure state and X-bits `11` clear it. X-bits `01` or `10` leave it unchanged, and so do cycles without a strobe. The new state is visible one clock after the strobe.
- R2: The register at address 0x11 reads {3'b000, far-end failure, application-id bit, FEBE[2:0]}, bit 7 first. FEBE holds the field of the latest frame and is 3'b111 after reset.
- R3: `febe_err` is high for exactly the one clock that follows a frame strobe whose FEBE field is not 3'b111. It is low at every other time.
- R4: The idle counter steps up on an idle frame and down on a non-idle frame, and it saturates at 0 and at 15. The idle state is declared when the counter reaches 15. It is released only when the counter has come back to 0.
- R5: The register at address 0x10 reads {AIS, LOS, idle, OOF, ctrl[3:0]}, bit 7 first. The upper four bits are read-only. ctrl[3:0] is written through this address and resets to 0.
- R6: The interrupt status register at address 0x13 has these bits, from bit 7 down to bit 0: C-bit error, LOS change, AIS change, idle change, far-end failure change, application-id change, OOF change, P-bit error. A change bit is set when its state asserts and also when it clears. The two error bits are set by every frame strobe that flags that error.
- R7: A read of address 0x13 clears all of its bits at the end of the read cycle. An event that occurs in that same cycle still leaves its bit set.
- R8: The interrupt enable register at address 0x12 can be read and written and resets to 0. Its bits line up with those of the register at 0x13. `irq` is high exactly when some bit is set in both registers.
- R9: After reset, the far-end failure state is 0, the idle state is 0, the latched interrupts are 0, the enables are 0 and `irq` is low.
- R10: `cpu_rdata` is 0 whenever `cpu_rd` is low and whenever the address is not one of 0x10 to 0x13. A write to 0x11, to 0x13 or to an unmapped address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_vld | input | 1 | One-cycle strobe per received M-frame |
| frm_xbits | input | 2 | X-bits of the frame |
| frm_febe | input | 3 | FEBE bits of the frame |
| frm_idle | input | 1 | Frame matched the idle pattern |
| frm_perr | input | 1 | P-bit parity error in the frame |
| frm_cperr | input | 1 | C-bit parity error in the frame |
| ais_in | input | 1 | Alarm indication signal level |
| los_in | input | 1 | Loss of signal level |
| oof_in | input | 1 | Out of frame level |
| aic_in | input | 1 | Application identification bit level |
| cpu_addr | input | 8 | Register address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, combinational |
| irq | output | 1 | Interrupt request |
| febe_err | output | 1 | Far-end block error pulse |

## Verification
The hardest state to reach from the ports is the release of the idle condition. It needs a full run of idle frames to declare idle, and then a run of non-idle frames long enough to empty the counter. A single stray idle frame in that second run pushes the release back. Directed runs of 14 and 15 frames in each direction probe both edges of the hysteresis. A random phase then alternates long stretches that are biased towards idle and towards non-idle. A second awkward case is an event that lands in the same cycle as the clearing read. It is driven on purpose, and the following read must still show that bit.

// File: rtl/ds3_mon_pkg.sv
// Package: shared register addresses, interrupt bit positions and the
// per-frame overhead record used inside the DS3 receive alarm monitor.
package ds3_mon_pkg;

    localparam int REG_W = 8;

    // Register addresses seen on the microprocessor port
    localparam logic [7:0] ADR_CFG  = 8'h10;
    localparam logic [7:0] ADR_STAT = 8'h11;
    localparam logic [7:0] ADR_IEN  = 8'h12;
    localparam logic [7:0] ADR_ISR  = 8'h13;

    // Interrupt status bit positions (software decodes these)
    localparam int IB_CPERR = 7;
    localparam int IB_LOS   = 6;
    localparam int IB_AIS   = 5;
    localparam int IB_IDLE  = 4;
    localparam int IB_FERF  = 3;
    localparam int IB_AIC   = 2;
    localparam int IB_OOF   = 1;
    localparam int IB_PERR  = 0;

    // Number of externally detected line conditions
    localparam int N_LINE = 4;
    // Index of each line condition inside the sampled vector
    localparam int LN_AIC = 0;
    localparam int LN_OOF = 1;
    localparam int LN_LOS = 2;
    localparam int LN_AIS = 3;

    // Overhead fields delivered with each M-frame strobe
    typedef struct packed {
        logic [1:0] xbits;
        logic [2:0] febe;
        logic       idle;
        logic       perr;
        logic       cperr;
    } ds3_oh_t;

endpackage

// File: rtl/ds3_far_end_mon.sv
// Module: ds3_far_end_mon
// Tracks the far-end receive failure state from the X-bit pair of each frame.
// It keeps the latest FEBE field and pulses an error flag for each
// FEBE value other than all ones.
// Assumes: vld is high for a single cycle per M-frame; fields valid with vld.
module ds3_far_end_mon
    import ds3_mon_pkg::*;
#(
    parameter int FEBE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld,
    input  ds3_oh_t           oh,
    output logic              ferf,
    output logic              ferf_chg,
    output logic [FEBE_W-1:0] febe_q,
    output logic              febe_err
);

    localparam logic [FEBE_W-1:0] FEBE_CLEAN = '1;

    logic ferf_nxt;

    // Next far-end failure state: 00 declares, 11 releases, others hold
    always_comb begin
        ferf_nxt = ferf;
        if (vld) begin
            if (oh.xbits == 2'b00)
                ferf_nxt = 1'b1;
            else if (oh.xbits == 2'b11)
                ferf_nxt = 1'b0;
        end
    end

    // Change indication feeds the interrupt latch at the same edge
    assign ferf_chg = (ferf_nxt != ferf);

    // Far-end failure state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            ferf <= 1'b0;
        else
            ferf <= ferf_nxt;
    end

    // FEBE capture and one-cycle error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            febe_q   <= FEBE_CLEAN;
            febe_err <= 1'b0;
        end else begin
            febe_err <= vld && (oh.febe != FEBE_CLEAN);
            if (vld)
                febe_q <= oh.febe;
        end
    end

endmodule

// File: rtl/ds3_idle_tracker.sv
// Module: ds3_idle_tracker
// Saturating up/down counter with hysteresis for the idle-signal condition.
// Idle is declared when the counter reaches IDLE_MAX and is released when
// it returns to zero.
// Assumes: vld is a one-cycle frame strobe; IDLE_MAX >= 1.
module ds3_idle_tracker #(
    parameter int IDLE_MAX = 15,
    localparam int CNT_W   = $clog2(IDLE_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld,
    input  logic             is_idle,
    output logic [CNT_W-1:0] cnt,
    output logic             idle,
    output logic             idle_chg
);

    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(IDLE_MAX);

    logic [CNT_W-1:0] cnt_nxt;
    logic             idle_nxt;

    // Counter step with saturation at both ends
    always_comb begin
        cnt_nxt = cnt;
        if (vld) begin
            if (is_idle) begin
                if (cnt != CNT_TOP)
                    cnt_nxt = cnt + 1'b1;
            end else begin
                if (cnt != '0)
                    cnt_nxt = cnt - 1'b1;
            end
        end
    end

    // Hysteresis: declare at the top, release at zero, hold in between
    always_comb begin
        idle_nxt = idle;
        if (cnt_nxt == CNT_TOP)
            idle_nxt = 1'b1;
        else if (cnt_nxt == '0)
            idle_nxt = 1'b0;
    end

    assign idle_chg = (idle_nxt != idle);

    // Counter and state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            idle <= 1'b0;
        end else begin
            cnt  <= cnt_nxt;
            idle <= idle_nxt;
        end
    end

endmodule

// File: rtl/ds3_int_regs.sv
// Module: ds3_int_regs
// Latched interrupt status with clear-on-read and an enable register that
// produces the interrupt request.
// Assumes: set has priority over the read clear in the same cycle.
module ds3_int_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         rd_clr,
    input  logic         en_wr,
    input  logic [W-1:0] en_wdata,
    output logic [W-1:0] isr,
    output logic [W-1:0] ien,
    output logic         irq
);

    // One latch cell per interrupt source
    for (genvar i = 0; i < W; i++) begin : g_bit
        // Sticky bit: set wins, otherwise clear on read, otherwise hold
        always_ff @(posedge clk) begin
            if (!rst_n)
                isr[i] <= 1'b0;
            else if (set_vec[i])
                isr[i] <= 1'b1;
            else if (rd_clr)
                isr[i] <= 1'b0;
        end
    end

    // Enable register written by software
    always_ff @(posedge clk) begin
        if (!rst_n)
            ien <= '0;
        else if (en_wr)
            ien <= en_wdata;
    end

    // Request while any enabled bit is pending
    assign irq = |(isr & ien);

endmodule

// File: rtl/ds3_rx_alarm_mon.sv
// Module: ds3_rx_alarm_mon (top)
// DS3 receive alarm monitor. Combines the far-end failure tracker, the idle
// tracker, the sampled line conditions and the interrupt latch, and
// presents them on a byte-wide register port.
// Assumes: reads and writes are single-cycle strobes. Read data is
// combinational, and clear-on-read applies at the edge that ends the read.
module ds3_rx_alarm_mon
    import ds3_mon_pkg::*;
#(
    parameter int IDLE_MAX = 15,
    parameter int CTRL_W   = 4,
    localparam int CNT_W   = $clog2(IDLE_MAX + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frm_vld,
    input  logic [1:0] frm_xbits,
    input  logic [2:0] frm_febe,
    input  logic       frm_idle,
    input  logic       frm_perr,
    input  logic       frm_cperr,
    input  logic       ais_in,
    input  logic       los_in,
    input  logic       oof_in,
    input  logic       aic_in,
    input  logic [7:0] cpu_addr,
    input  logic       cpu_rd,
    input  logic       cpu_wr,
    input  logic [7:0] cpu_wdata,
    output logic [7:0] cpu_rdata,
    output logic       irq,
    output logic       febe_err
);

    ds3_oh_t           oh;
    logic              ferf_st;
    logic              ferf_chg;
    logic [2:0]        febe_q;
    logic [CNT_W-1:0]  idle_cnt;
    logic              idle_st;
    logic              idle_chg;
    logic [N_LINE-1:0] line_raw;
    logic [N_LINE-1:0] line_q;
    logic [N_LINE-1:0] line_chg;
    logic [CTRL_W-1:0] ctrl_q;
    logic [REG_W-1:0]  int_set;
    logic [REG_W-1:0]  int_stat;
    logic [REG_W-1:0]  int_en;
    logic              isr_rd;
    logic              ien_wr;
    logic              cfg_wr;

    // Pack the frame overhead into the shared record
    assign oh = '{xbits: frm_xbits, febe: frm_febe, idle: frm_idle,
                  perr: frm_perr, cperr: frm_cperr};

    // Far-end failure and FEBE
    ds3_far_end_mon #(.FEBE_W(3)) u_far (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld      (frm_vld),
        .oh       (oh),
        .ferf     (ferf_st),
        .ferf_chg (ferf_chg),
        .febe_q   (febe_q),
        .febe_err (febe_err)
    );

    // Idle hysteresis counter
    ds3_idle_tracker #(.IDLE_MAX(IDLE_MAX)) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld      (frm_vld),
        .is_idle  (oh.idle),
        .cnt      (idle_cnt),
        .idle     (idle_st),
        .idle_chg (idle_chg)
    );

    // Gather the externally detected line conditions
    assign line_raw[LN_AIC] = aic_in;
    assign line_raw[LN_OOF] = oof_in;
    assign line_raw[LN_LOS] = los_in;
    assign line_raw[LN_AIS] = ais_in;

    // One sampling register and change detector per line condition
    for (genvar k = 0; k < N_LINE; k++) begin : g_line
        // Sample the level; a difference from the stored value is a change
        always_ff @(posedge clk) begin
            if (!rst_n)
                line_q[k] <= 1'b0;
            else
                line_q[k] <= line_raw[k];
        end
        assign line_chg[k] = (line_raw[k] != line_q[k]);
    end

    // Interrupt set vector, one source per bit position
    always_comb begin
        int_set           = '0;
        int_set[IB_CPERR] = frm_vld && oh.cperr;
        int_set[IB_LOS]   = line_chg[LN_LOS];
        int_set[IB_AIS]   = line_chg[LN_AIS];
        int_set[IB_IDLE]  = idle_chg;
        int_set[IB_FERF]  = ferf_chg;
        int_set[IB_AIC]   = line_chg[LN_AIC];
        int_set[IB_OOF]   = line_chg[LN_OOF];
        int_set[IB_PERR]  = frm_vld && oh.perr;
    end

    // Register port decodes
    assign isr_rd = cpu_rd && (cpu_addr == ADR_ISR);
    assign ien_wr = cpu_wr && (cpu_addr == ADR_IEN);
    assign cfg_wr = cpu_wr && (cpu_addr == ADR_CFG);

    ds3_int_regs #(.W(REG_W)) u_int (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (int_set),
        .rd_clr   (isr_rd),
        .en_wr    (ien_wr),
        .en_wdata (cpu_wdata),
        .isr      (int_stat),
        .ien      (int_en),
        .irq      (irq)
    );

    // Writable control bits of the configuration register
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (cfg_wr)
            ctrl_q <= cpu_wdata[CTRL_W-1:0];
    end

    // Read multiplexer, zero when idle or unmapped
    always_comb begin
        cpu_rdata = '0;
        if (cpu_rd) begin
            case (cpu_addr)
                ADR_CFG:  cpu_rdata = {line_q[LN_AIS], line_q[LN_LOS], idle_st,
                                       line_q[LN_OOF], ctrl_q};
                ADR_STAT: cpu_rdata = {3'b000, ferf_st, line_q[LN_AIC], febe_q};
                ADR_IEN:  cpu_rdata = int_en;
                ADR_ISR:  cpu_rdata = int_stat;
                default:  cpu_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/ds3_rx_alarm_mon_chk.sv
// Module: ds3_rx_alarm_mon_chk
// Property checker for the DS3 receive alarm monitor, attached by bind.
// Assumes: the signal names of the top module listed in the bind below.
module ds3_rx_alarm_mon_chk #(
    parameter int IDLE_MAX = 15,
    localparam int CNT_W   = $clog2(IDLE_MAX + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frm_vld,
    input logic [1:0]       frm_xbits,
    input logic [2:0]       frm_febe,
    input logic             cpu_rd,
    input logic [7:0]       cpu_rdata,
    input logic             irq,
    input logic             febe_err,
    input logic             ferf_st,
    input logic             idle_st,
    input logic [CNT_W-1:0] idle_cnt,
    input logic [7:0]       int_stat
);

    // R1
    ferf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && frm_xbits == 2'b00) |=> ferf_st);

    // R1
    ferf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && frm_xbits == 2'b11) |=> !ferf_st);

    // R1
    ferf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_vld |=> $stable(ferf_st));

    // R6
    ferf_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ferf_st) || $fell(ferf_st)) |-> int_stat[3]);

    // R6
    idle_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(idle_st) || $fell(idle_st)) |-> int_stat[4]);

    // R4
    idle_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_st) |-> (idle_cnt == CNT_W'(IDLE_MAX)));

    // R4
    idle_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(idle_st) |-> (idle_cnt == '0));

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cnt <= CNT_W'(IDLE_MAX));

    // R3
    febe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        febe_err |-> $past(frm_vld && frm_febe != 3'b111));

    // R8
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (int_stat != 8'h00));

    // R10
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd |-> (cpu_rdata == 8'h00));

endmodule

bind ds3_rx_alarm_mon ds3_rx_alarm_mon_chk #(.IDLE_MAX(IDLE_MAX)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frm_vld   (frm_vld),
    .frm_xbits (frm_xbits),
    .frm_febe  (frm_febe),
    .cpu_rd    (cpu_rd),
    .cpu_rdata (cpu_rdata),
    .irq       (irq),
    .febe_err  (febe_err),
    .ferf_st   (ferf_st),
    .idle_st   (idle_st),
    .idle_cnt  (idle_cnt),
    .int_stat  (int_stat)
);

// File: tb/ds3_rx_alarm_mon_tb.sv
// Testbench: directed corner cases plus seeded random traffic, each compared
// against a behavioural model kept in the bench.
module ds3_rx_alarm_mon_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frm_vld = 1'b0;
    logic [1:0] frm_xbits = 2'b11;
    logic [2:0] frm_febe = 3'b111;
    logic       frm_idle = 1'b0;
    logic       frm_perr = 1'b0;
    logic       frm_cperr = 1'b0;
    logic       ais_in = 1'b0;
    logic       los_in = 1'b0;
    logic       oof_in = 1'b0;
    logic       aic_in = 1'b0;
    logic [7:0] cpu_addr = 8'h00;
    logic       cpu_rd = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       irq;
    logic       febe_err;

    int n_chk = 0;
    int n_bad = 0;

    // Model state
    logic       m_ferf, m_idle, m_febe_err;
    int         m_cnt;
    logic [2:0] m_febe;
    logic [3:0] m_line;   // {ais, los, oof, aic}
    logic [3:0] m_ctrl;
    logic [7:0] m_isr, m_en;

    always #4 clk = ~clk;   // 125 MHz

    ds3_rx_alarm_mon u_dut (
        .clk(clk), .rst_n(rst_n), .frm_vld(frm_vld), .frm_xbits(frm_xbits),
        .frm_febe(frm_febe), .frm_idle(frm_idle), .frm_perr(frm_perr),
        .frm_cperr(frm_cperr), .ais_in(ais_in), .los_in(los_in),
        .oof_in(oof_in), .aic_in(aic_in), .cpu_addr(cpu_addr),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .irq(irq), .febe_err(febe_err)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [7:0] a);
        case (a)
            8'h10:   return {m_line[3], m_line[2], m_idle, m_line[1], m_ctrl};
            8'h11:   return {3'b000, m_ferf, m_line[0], m_febe};
            8'h12:   return m_en;
            8'h13:   return m_isr;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h10:   return "R5";
            8'h11:   return "R2";
            8'h12:   return "R8";
            8'h13:   return "R6";
            default: return "R10";
        endcase
    endfunction

    task automatic model_reset();
        m_ferf = 0; m_idle = 0; m_febe_err = 0; m_cnt = 0; m_febe = 3'b111;
        m_line = 0; m_ctrl = 0; m_isr = 0; m_en = 0;
    endtask

    // One clock: drive at negedge, check read data, model the edge, check outputs
    task automatic step(input logic v, input logic [1:0] x, input logic [2:0] fb,
                        input logic id, input logic pe, input logic ce,
                        input logic [3:0] ln, input logic rd, input logic wr,
                        input logic [7:0] a, input logic [7:0] wd, input string tag);
        logic [7:0] set;
        logic       fn;
        int         cn;
        frm_vld = v; frm_xbits = x; frm_febe = fb; frm_idle = id;
        frm_perr = pe; frm_cperr = ce;
        ais_in = ln[3]; los_in = ln[2]; oof_in = ln[1]; aic_in = ln[0];
        cpu_rd = rd; cpu_wr = wr; cpu_addr = a; cpu_wdata = wd;
        #1;
        if (rd) check(cpu_rdata, model_read(a), (tag != "") ? tag : tag_of(a));
        else    check(cpu_rdata, 8'h00, "R10");
        @(posedge clk);
        set = 0;
        fn = m_ferf;
        cn = m_cnt;
        m_febe_err = v && (fb != 3'b111);
        if (v) begin
            set[7] = ce;
            set[0] = pe;
            if (x == 2'b00) fn = 1;
            else if (x == 2'b11) fn = 0;
            if (id) begin if (cn < 15) cn++; end
            else begin if (cn > 0) cn--; end
            m_febe = fb;
        end
        if (fn != m_ferf) set[3] = 1;
        m_ferf = fn;
        m_cnt = cn;
        if (cn == 15 && !m_idle) begin m_idle = 1; set[4] = 1; end
        if (cn == 0 && m_idle)   begin m_idle = 0; set[4] = 1; end
        if (ln[3] != m_line[3]) set[5] = 1;
        if (ln[2] != m_line[2]) set[6] = 1;
        if (ln[1] != m_line[1]) set[1] = 1;
        if (ln[0] != m_line[0]) set[2] = 1;
        m_line = ln;
        m_isr = ((rd && a == 8'h13) ? 8'h00 : m_isr) | set;
        if (wr && a == 8'h10) m_ctrl = wd[3:0];
        if (wr && a == 8'h12) m_en = wd;
        @(negedge clk);
        check({7'd0, febe_err}, {7'd0, m_febe_err}, "R3");
        check({7'd0, irq}, {7'd0, |(m_isr & m_en)}, "R8");
        frm_vld = 0; cpu_rd = 0; cpu_wr = 0;
    endtask

    task automatic frame(input logic [1:0] x, input logic [2:0] fb, input logic id,
                         input logic pe, input logic ce);
        step(1, x, fb, id, pe, ce, m_line, 0, 0, 8'h00, 8'h00, "");
    endtask

    task automatic rd_reg(input logic [7:0] a, input string tag);
        step(0, 2'b11, 3'b111, 0, 0, 0, m_line, 1, 0, a, 8'h00, tag);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        step(0, 2'b11, 3'b111, 0, 0, 0, m_line, 0, 1, a, d, "");
    endtask

    // Watchdog: an expired run counts as a failure and still reports
    initial begin
        #(8 * 190000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int bias;
        void'($urandom(32'h0d53_a1e7));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R9: reset state
        check({7'd0, irq}, 8'h00, "R9");
        rd_reg(8'h13, "R9");
        rd_reg(8'h12, "R9");
        rd_reg(8'h10, "R9");
        rd_reg(8'h11, "R9");

        // R1: declare, hold on mixed bits, release
        wr_reg(8'h12, 8'h08);
        frame(2'b00, 3'b111, 0, 0, 0);
        rd_reg(8'h11, "R1");
        frame(2'b01, 3'b111, 0, 0, 0);
        frame(2'b10, 3'b111, 0, 0, 0);
        rd_reg(8'h11, "R1");
        rd_reg(8'h13, "R6");
        rd_reg(8'h13, "R7");
        frame(2'b11, 3'b111, 0, 0, 0);
        rd_reg(8'h11, "R1");
        rd_reg(8'h13, "R6");

        // R3 and R2: FEBE capture and pulse
        frame(2'b11, 3'b010, 0, 0, 0);
        rd_reg(8'h11, "R2");
        frame(2'b11, 3'b111, 0, 0, 0);

        // R4: idle hysteresis edges
        for (int i = 0; i < 14; i++) frame(2'b11, 3'b111, 1, 0, 0);
        rd_reg(8'h10, "R4");
        frame(2'b11, 3'b111, 1, 0, 0);
        rd_reg(8'h10, "R4");
        frame(2'b11, 3'b111, 1, 0, 0);
        rd_reg(8'h13, "R4");
        for (int i = 0; i < 14; i++) frame(2'b11, 3'b111, 0, 0, 0);
        rd_reg(8'h10, "R4");
        frame(2'b11, 3'b111, 0, 0, 0);
        rd_reg(8'h10, "R4");
        rd_reg(8'h13, "R4");

        // R7: event in the same cycle as the clearing read survives
        step(1, 2'b11, 3'b111, 0, 1, 1, m_line, 1, 0, 8'h13, 8'h00, "R7");
        rd_reg(8'h13, "R7");

        // R5 and R10: control write, ignored writes, unmapped read
        wr_reg(8'h10, 8'hfa);
        rd_reg(8'h10, "R5");
        wr_reg(8'h11, 8'hff);
        wr_reg(8'h13, 8'hff);
        wr_reg(8'h40, 8'hff);
        rd_reg(8'h11, "R10");
        rd_reg(8'h13, "R10");
        rd_reg(8'h40, "R10");

        // R6: line condition change both ways
        step(0, 2'b11, 3'b111, 0, 0, 0, 4'b1111, 0, 0, 8'h00, 8'h00, "");
        rd_reg(8'h13, "R6");
        rd_reg(8'h10, "R5");
        step(0, 2'b11, 3'b111, 0, 0, 0, 4'b0000, 0, 0, 8'h00, 8'h00, "");
        rd_reg(8'h13, "R6");

        // Random phase with idle bias sweeps
        bias = 85;
        for (int n = 0; n < 6000; n++) begin
            int r;
            logic [7:0] ra;
            if (n % 250 == 0) bias = (bias == 85) ? 15 : 85;
            r = $urandom_range(0, 9);
            ra = ($urandom_range(0, 4) == 4) ? 8'($urandom) : 8'(8'h10 + $urandom_range(0, 3));
            if (r < 5)
                step(1, 2'($urandom), ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b111,
                     $urandom_range(0, 99) < bias, $urandom_range(0, 9) == 0,
                     $urandom_range(0, 9) == 0,
                     ($urandom_range(0, 19) == 0) ? (m_line ^ 4'(1 << $urandom_range(0, 3))) : m_line,
                     0, 0, 8'h00, 8'h00, "");
            else if (r < 8)
                step($urandom_range(0, 1) == 1, 2'($urandom), 3'($urandom), 1'($urandom),
                     1'($urandom), 1'($urandom), m_line, 1, 0, ra, 8'h00, "");
            else if (r == 8)
                step(0, 2'b11, 3'b111, 0, 0, 0, m_line, 0, 1, ra, 8'($urandom), "");
            else
                step(0, 2'b11, 3'b111, 0, 0, 0, 4'($urandom), 0, 0, 8'h00, 8'h00, "");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule